// File: doc/BRIEF.md
# Programmable sinc decimation filter

This block turns a one-bit oversampled bitstream into signed 24-bit conversion results. Each accepted bit is taken as +1 or -1 and passed through a cascade of integrators. Every R = 64 x FS accepted bits, the integrator output is decimated through an equal number of differencing stages. FS is a 10-bit rate word. The cascade order is either three or four, so the overall response is a sinc of that order. The block also contains the conversion timing. It counts decimation points after a restart, and it holds back any result whose window still reaches into samples taken before the restart.

A restart pulse marks a channel change. It clears the whole filter and loads the order, rate word and zero-latency choice as the active configuration. These inputs are read at no other time. In normal mode, results appear once every R samples after the first N decimation points, where N is the order. In zero-latency mode, every conversion covers N x R samples and starts from a cleared filter, so each result is fully settled whatever happened before it.

Top module: `sinc_decim_filter`

## Requirements
- R1: After reset, result is 0 and result_valid is 0. Until the first restart, the active configuration is fourth order, FS = 1 and zero latency off.
- R2: An accepted bit of 1 counts as +1 and a bit of 0 counts as -1. A result equals the sinc filter output over the samples since the last clear, arithmetic-shifted right by max(N x (6 + ceil(log2 FS)) - 22, 0) and cut to 24 signed bits. The sinc filter output is N cascaded boxcar sums of length R. A clear is a restart or a zero-latency boundary.
- R3: The rate word, order select and zero-latency enable are sampled only on restart, and changes at other times have no effect. A rate word of 0 acts as 1.
- R4: In normal mode, no result is produced before the N-th decimation point after a restart. After that, exactly one result is produced per R accepted samples.
- R5: With zero_lat = 1, each conversion spans N x R accepted samples. The filter is cleared after each result, so one result is produced per N x R samples.
- R6: order_sel = 1 selects a fourth-order response and order_sel = 0 selects a third-order response. For example, with FS = 1 and all ones, third order settles to 262144.
- R7: result_valid is a one-cycle pulse. It is high in the cycle after the clock edge that accepts the sample completing a conversion. result holds its value until the next pulse.
- R8: A restart in the same cycle as a sample discards that sample and cancels the result it would have completed. The new conversion then starts from a cleared filter.
- R9: After an input step inside a conversion, the first fully settled result is the (N+1)-th result after the step. A step on a conversion boundary settles on the N-th result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mod_bit | input | 1 | Bitstream sample, 1 means +1 and 0 means -1 |
| mod_valid | input | 1 | The sample on mod_bit is accepted this cycle |
| rate_word | input | 10 | Rate word FS, decimation ratio 64 x FS |
| order_sel | input | 1 | 1 selects fourth order, 0 selects third order |
| zl_en | input | 1 | 1 selects zero-latency conversions |
| restart | input | 1 | Channel change: clears the filter and loads the configuration |
| result | output | 24 | Signed conversion result |
| result_valid | output | 1 | One-cycle data-ready strobe |

## Verification
A restart can arrive in the same cycle as the sample that would complete a settled conversion. The bench provokes this by driving restart together with the 256th sample of a run of ones. It judges the outcome by the absence of any pulse, and by the fact that 255 further samples still produce nothing while the 256th produces a fresh result of -4194304. In zero-latency mode, the filter clear falls in the same cycle as the accepted sample whose value it must still include. The scoreboard compares those results with an FIR model rebuilt from the samples since the last clear.

// File: rtl/sinc_pkg.sv
package sinc_pkg;
  parameter int OSR_LOG2  = 6;
  parameter int RATE_W    = 10;
  parameter int ORDER_MAX = 4;
  parameter int ORDER_MIN = 3;
  parameter int RES_W     = 24;
  parameter int HEADROOM  = 2;

  localparam int RATIO_W = OSR_LOG2 + RATE_W;
  localparam int ACC_W   = ORDER_MAX * RATIO_W + 1;
  localparam int CONV_W  = $clog2(ORDER_MAX + 1);
  localparam int KEEP_W  = RES_W - HEADROOM;

  typedef struct packed {
    logic              order_hi;
    logic              zero_lat;
    logic [RATE_W-1:0] rate;
  } sinc_cfg_t;

  function automatic logic [RATE_W-1:0] legal_rate(input logic [RATE_W-1:0] w);
    return (w == '0) ? RATE_W'(1) : w;
  endfunction

  function automatic int order_of(input logic order_hi);
    return order_hi ? ORDER_MAX : ORDER_MIN;
  endfunction

  function automatic int rate_log2_ceil(input logic [RATE_W-1:0] fs);
    int l;
    l = 0;
    for (int i = 0; i < RATE_W; i++) begin
      if ((32'd1 << l) < 32'(fs)) l = l + 1;
    end
    return l;
  endfunction

  function automatic int out_shift(input sinc_cfg_t c);
    int bits;
    bits = order_of(c.order_hi) * (OSR_LOG2 + rate_log2_ceil(c.rate));
    return (bits > KEEP_W) ? bits - KEEP_W : 0;
  endfunction
endpackage

// File: rtl/sinc_rate_ctrl.sv
module sinc_rate_ctrl
  import sinc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mod_valid,
  input  logic              restart,
  input  logic [RATE_W-1:0] rate_word,
  input  logic              order_sel,
  input  logic              zl_en,
  output sinc_cfg_t         cfg,
  output logic              take,
  output logic              dec_tick,
  output logic              emit_now,
  output logic              conv_clear
);
  logic [RATIO_W-1:0] samp_cnt;
  logic [RATIO_W-1:0] ratio;
  logic [CONV_W-1:0]  conv_cnt;
  logic [CONV_W-1:0]  conv_last;
  logic               period_end;

  assign ratio      = {cfg.rate, {OSR_LOG2{1'b0}}};
  assign take       = mod_valid & ~restart;
  assign period_end = (samp_cnt == ratio - RATIO_W'(1));
  assign conv_last  = CONV_W'(order_of(cfg.order_hi) - 1);
  assign dec_tick   = take & period_end;
  assign emit_now   = dec_tick & (conv_cnt == conv_last);
  assign conv_clear = emit_now & cfg.zero_lat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg      <= '{order_hi: 1'b1, zero_lat: 1'b0, rate: RATE_W'(1)};
      samp_cnt <= '0;
      conv_cnt <= '0;
    end else if (restart) begin
      cfg      <= '{order_hi: order_sel, zero_lat: zl_en, rate: legal_rate(rate_word)};
      samp_cnt <= '0;
      conv_cnt <= '0;
    end else if (take) begin
      samp_cnt <= period_end ? '0 : samp_cnt + RATIO_W'(1);
      if (dec_tick) begin
        if (conv_clear)
          conv_cnt <= '0;
        else if (conv_cnt != conv_last)
          conv_cnt <= conv_cnt + CONV_W'(1);
      end
    end
  end

  AST_RATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) cfg.rate != '0); // R3
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !restart |=> $stable(cfg)); // R3
  AST_PERIOD_BOUND: assert property (@(posedge clk) disable iff (!rst_n) samp_cnt < ratio); // R4
  AST_CONV_BOUND: assert property (@(posedge clk) disable iff (!rst_n) conv_cnt <= conv_last); // R4
  AST_ZL_REARM: assert property (@(posedge clk) disable iff (!rst_n) conv_clear |=> (conv_cnt == '0 && samp_cnt == '0)); // R5
endmodule

// File: rtl/sinc_integ_chain.sv
module sinc_integ_chain
  import sinc_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              take,
  input  logic                              flush,
  input  logic                              mod_bit,
  output logic [ORDER_MAX-1:0][ACC_W-1:0]   sum_nxt
);
  logic [ORDER_MAX-1:0][ACC_W-1:0] acc;
  logic [ACC_W-1:0]                step_val;

  assign step_val = mod_bit ? ACC_W'(1) : {ACC_W{1'b1}};

  for (genvar g = 0; g < ORDER_MAX; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign sum_nxt[g] = acc[g] + step_val;
    end else begin : g_rest
      assign sum_nxt[g] = acc[g] + sum_nxt[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush)
      acc <= '0;
    else if (take)
      acc <= sum_nxt;
  end

  AST_BIT_MAP: assert property (@(posedge clk) disable iff (!rst_n) (take && !flush) |=> ((acc[0] - $past(acc[0])) == ($past(mod_bit) ? ACC_W'(1) : {ACC_W{1'b1}}))); // R2
endmodule

// File: rtl/sinc_comb_chain.sv
module sinc_comb_chain
  import sinc_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              dec_tick,
  input  logic                              flush,
  input  logic                              order_hi,
  input  logic [ORDER_MAX-1:0][ACC_W-1:0]   integ_nxt,
  output logic signed [ACC_W-1:0]           comb_out
);
  logic [ORDER_MAX:0][ACC_W-1:0]   stage_in;
  logic [ORDER_MAX-1:0][ACC_W-1:0] dly;

  assign stage_in[0] = order_hi ? integ_nxt[ORDER_MAX-1] : integ_nxt[ORDER_MIN-1];

  for (genvar g = 0; g < ORDER_MAX; g++) begin : g_diff
    assign stage_in[g+1] = stage_in[g] - dly[g];
  end

  assign comb_out = $signed(order_hi ? stage_in[ORDER_MAX] : stage_in[ORDER_MIN]);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      dly <= '0;
    end else if (dec_tick) begin
      for (int i = 0; i < ORDER_MAX; i++) dly[i] <= stage_in[i];
    end
  end
endmodule

// File: rtl/sinc_out_stage.sv
module sinc_out_stage
  import sinc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     emit_now,
  input  sinc_cfg_t                cfg,
  input  logic signed [ACC_W-1:0]  comb_out,
  output logic signed [RES_W-1:0]  result,
  output logic                     result_valid
);
  logic signed [ACC_W-1:0] scaled;

  assign scaled = comb_out >>> out_shift(cfg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result       <= '0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= emit_now;
      if (emit_now) result <= scaled[RES_W-1:0];
    end
  end

  AST_FITS_WORD: assert property (@(posedge clk) disable iff (!rst_n) emit_now |-> ((&scaled[ACC_W-1:RES_W-1]) || !(|scaled[ACC_W-1:RES_W-1]))); // R2
  AST_DRDY_PULSE: assert property (@(posedge clk) disable iff (!rst_n) result_valid |=> !result_valid); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !result_valid |-> $stable(result)); // R7
endmodule

// File: rtl/sinc_decim_filter.sv
module sinc_decim_filter
  import sinc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mod_bit,
  input  logic                     mod_valid,
  input  logic [RATE_W-1:0]        rate_word,
  input  logic                     order_sel,
  input  logic                     zl_en,
  input  logic                     restart,
  output logic signed [RES_W-1:0]  result,
  output logic                     result_valid
);
  sinc_cfg_t                       cfg;
  logic                            take;
  logic                            dec_tick;
  logic                            emit_now;
  logic                            conv_clear;
  logic                            flush;
  logic [ORDER_MAX-1:0][ACC_W-1:0] integ_nxt;
  logic signed [ACC_W-1:0]         comb_out;

  assign flush = restart | conv_clear;

  sinc_rate_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .mod_valid(mod_valid), .restart(restart),
    .rate_word(rate_word), .order_sel(order_sel), .zl_en(zl_en),
    .cfg(cfg), .take(take), .dec_tick(dec_tick), .emit_now(emit_now),
    .conv_clear(conv_clear)
  );

  sinc_integ_chain u_integ (
    .clk(clk), .rst_n(rst_n), .take(take), .flush(flush),
    .mod_bit(mod_bit), .sum_nxt(integ_nxt)
  );

  sinc_comb_chain u_comb (
    .clk(clk), .rst_n(rst_n), .dec_tick(dec_tick), .flush(flush),
    .order_hi(cfg.order_hi), .integ_nxt(integ_nxt), .comb_out(comb_out)
  );

  sinc_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .emit_now(emit_now), .cfg(cfg),
    .comb_out(comb_out), .result(result), .result_valid(result_valid)
  );

  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n) restart |=> !result_valid); // R8
endmodule

// File: tb/tb_sinc_decim_filter.sv
`timescale 1ns/1ps
module tb_sinc_decim_filter;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic               rst_n, mod_bit, mod_valid, order_sel, zl_en, restart;
  logic [9:0]         rate_word;
  logic signed [23:0] result;
  logic               result_valid;

  sinc_decim_filter dut (
    .clk(clk), .rst_n(rst_n), .mod_bit(mod_bit), .mod_valid(mod_valid),
    .rate_word(rate_word), .order_sel(order_sel), .zl_en(zl_en),
    .restart(restart), .result(result), .result_valid(result_valid)
  );

  int     n_checks = 0;
  int     n_fail   = 0;
  longint cyc      = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int val; longint due; string tag; } exp_t;
  exp_t   exp_q[$];
  int     got_log[$];
  string  cur_tag = "R1";

  // reference model state
  int     m_n, m_zl, m_fs, m_r, m_shift, m_cnt, m_conv;
  int     hist[$];
  longint h[$];
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic model_setup(input int n, input int zl, input int fs);
    int lg, p, bits;
    longint cur[$];
    m_n = n; m_zl = zl; m_fs = (fs == 0) ? 1 : fs;
    m_r = 64 * m_fs;
    lg = 0; p = 1;
    while (p < m_fs) begin p = p * 2; lg++; end
    bits = m_n * (6 + lg);
    m_shift = (bits > 22) ? bits - 22 : 0;
    cur.delete(); cur.push_back(1);
    for (int s = 0; s < m_n; s++) begin
      longint nxt[$];
      for (int i = 0; i < cur.size() + m_r - 1; i++) begin
        longint acc = 0;
        for (int j = 0; j < m_r; j++)
          if (i - j >= 0 && i - j < cur.size()) acc += cur[i-j];
        nxt.push_back(acc);
      end
      cur = nxt;
    end
    h = cur;
    hist.delete(); m_cnt = 0; m_conv = 0;
  endtask

  function automatic int model_value();
    longint y = 0;
    int n = hist.size();
    logic signed [23:0] t;
    for (int k = 0; k < h.size(); k++)
      if (n - 1 - k >= 0) y += h[k] * hist[n-1-k];
    y = y >>> m_shift;
    t = y[23:0];
    return int'(t);
  endfunction

  task automatic model_sample(input bit b);
    exp_t e;
    hist.push_back(b ? 1 : -1);
    if (hist.size() > 2000) void'(hist.pop_front());
    m_cnt++;
    if (m_cnt == m_r) begin
      m_cnt = 0;
      m_conv++;
      if (m_zl == 0 && m_conv >= m_n) begin
        e.val = model_value(); e.due = cyc + 1; e.tag = cur_tag;
        exp_q.push_back(e);
        m_conv = m_n;
      end else if (m_zl != 0 && m_conv == m_n) begin
        e.val = model_value(); e.due = cyc + 1; e.tag = cur_tag;
        exp_q.push_back(e);
        hist.delete(); m_conv = 0;
      end
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && result_valid) begin
      got_log.push_back(int'(result));
      if (exp_q.size() == 0) begin
        check(1'b0, "R4", "unexpected result pulse", longint'(result), 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(int'(result) == e.val, e.tag, "result value", longint'(result), e.val);
        check(cyc == e.due, "R7", "pulse cycle", cyc, e.due);
      end
    end
  end

  task automatic drive_sample(input bit b, input bit with_rst);
    @(negedge clk);
    mod_bit = b; mod_valid = 1'b1; restart = with_rst;
    if (with_rst) model_setup(order_sel ? 4 : 3, zl_en, rate_word);
    else model_sample(b);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      mod_valid = 1'b0; restart = 1'b0;
    end
  endtask

  task automatic do_restart(input bit o4, input bit zl, input int fs);
    @(negedge clk);
    order_sel = o4; zl_en = zl; rate_word = 10'(fs);
    restart = 1'b1; mod_valid = 1'b0;
    model_setup(o4 ? 4 : 3, zl, fs);
  endtask

  task automatic send_stream(input int n, input int kind, input int gap);
    for (int i = 0; i < n; i++) begin
      bit b;
      case (kind)
        0: b = 1'b0;
        1: b = 1'b1;
        2: b = i[0];
        default: begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          b = lfsr[0];
        end
      endcase
      drive_sample(b, 1'b0);
      if (gap > 0) idle(gap);
    end
  endtask

  initial begin
    rst_n = 1'b0; mod_bit = 1'b0; mod_valid = 1'b0; restart = 1'b0;
    order_sel = 1'b0; zl_en = 1'b1; rate_word = 10'd7;
    model_setup(4, 0, 1);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(result == 24'sd0, "R1", "reset result", longint'(result), 0);
    check(result_valid == 1'b0, "R1", "reset valid", longint'(result_valid), 0);

    // R1: default configuration applies without any restart
    cur_tag = "R1"; got_log.delete();
    send_stream(4 * 64, 1, 0); idle(4);
    check(got_log.size() == 1, "R1", "default result count", got_log.size(), 1);
    if (got_log.size() > 0)
      check(got_log[0] == 4194304, "R1", "default settled value", got_log[0], 4194304);

    // R2 / R4: random and alternating bits, normal mode
    cur_tag = "R2"; do_restart(1'b1, 1'b0, 2); send_stream(6 * 128, 3, 2);
    cur_tag = "R4"; do_restart(1'b1, 1'b0, 1); send_stream(6 * 64, 2, 0);

    // R6: third order
    cur_tag = "R6"; do_restart(1'b0, 1'b0, 3); send_stream(5 * 192, 3, 0);
    do_restart(1'b0, 1'b0, 1); idle(1); got_log.delete();
    send_stream(3 * 64, 1, 0); idle(3);
    check(got_log.size() == 1, "R6", "third order result count", got_log.size(), 1);
    if (got_log.size() > 0)
      check(got_log[0] == 262144, "R6", "third order full scale", got_log[0], 262144);

    // R5: zero latency
    cur_tag = "R5"; do_restart(1'b1, 1'b1, 1); idle(1); got_log.delete();
    send_stream(3 * 4 * 64, 3, 0); idle(3);
    check(got_log.size() == 3, "R5", "zero-latency result count", got_log.size(), 3);
    do_restart(1'b0, 1'b1, 2); send_stream(2 * 3 * 128, 3, 1);

    // R3: inputs ignored without restart, rate word 0 acts as 1
    cur_tag = "R3"; do_restart(1'b1, 1'b0, 2); send_stream(4 * 128 + 40, 3, 0);
    rate_word = 10'd9; order_sel = 1'b0; zl_en = 1'b1;
    send_stream(3 * 128, 3, 0);
    do_restart(1'b1, 1'b0, 0); idle(1); got_log.delete();
    send_stream(4 * 64, 1, 0); idle(3);
    check(got_log.size() == 1, "R3", "rate 0 result count", got_log.size(), 1);
    if (got_log.size() > 0)
      check(got_log[0] == 4194304, "R3", "rate 0 acts as 1", got_log[0], 4194304);

    // R9: step inside a conversion, then on a boundary
    cur_tag = "R9"; do_restart(1'b1, 1'b0, 1); idle(1); got_log.delete();
    send_stream(4 * 64 + 32, 0, 0); send_stream(6 * 64 - 32, 1, 0); idle(3);
    check(got_log.size() == 7, "R9", "mid-step result count", got_log.size(), 7);
    if (got_log.size() >= 6) begin
      check(got_log[4] != 4194304, "R9", "4th after mid step unsettled", got_log[4], 0);
      check(got_log[5] == 4194304, "R9", "5th after mid step settled", got_log[5], 4194304);
    end
    do_restart(1'b1, 1'b0, 1); idle(1); got_log.delete();
    send_stream(4 * 64, 0, 0); send_stream(6 * 64, 1, 0); idle(3);
    check(got_log.size() == 7, "R9", "boundary step result count", got_log.size(), 7);
    if (got_log.size() >= 5) begin
      check(got_log[3] != 4194304, "R9", "3rd after boundary step unsettled", got_log[3], 0);
      check(got_log[4] == 4194304, "R9", "4th after boundary step settled", got_log[4], 4194304);
    end

    // R8: restart together with the completing sample
    cur_tag = "R8"; do_restart(1'b1, 1'b0, 1); idle(1); got_log.delete();
    send_stream(4 * 64 - 1, 1, 0);
    drive_sample(1'b1, 1'b1); idle(4);
    check(got_log.size() == 0, "R8", "cancelled result", got_log.size(), 0);
    send_stream(4 * 64 - 1, 0, 0); idle(3);
    check(got_log.size() == 0, "R8", "sample discarded on restart", got_log.size(), 0);
    send_stream(1, 0, 0); idle(3);
    check(got_log.size() == 1, "R8", "fresh conversion count", got_log.size(), 1);
    if (got_log.size() > 0)
      check(got_log[0] == -4194304, "R8", "fresh conversion value", got_log[0], -4194304);

    // R7: result holds between pulses
    idle(20);
    if (got_log.size() > 0)
      check(int'(result) == got_log[got_log.size()-1], "R7", "result held",
            longint'(result), got_log[got_log.size()-1]);
    check(result_valid == 1'b0, "R7", "valid low while idle", longint'(result_valid), 0);
    idle(5);
    check(exp_q.size() == 0, "R4", "outstanding expected results", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule